// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the step sequencer of a small 32-bit load/store processor that executes one datapath step per clock. It is a Moore machine: every control line it drives is a function of its current step alone, and the 6-bit opcode held in the instruction register is consulted only when the machine chooses where to go after the decode step. Five instruction classes are handled: register-register arithmetic, or-with-immediate, load word, store word and branch-if-equal. Any other opcode sends the machine back to fetch.

Each class takes its own number of clocks. The branch target is computed in the decode step, so a branch needs 3 cycles. R-type, or-immediate and store need 4, and load needs 5. Memory writes follow the rule that a write enable rises only one cycle after its address has settled, and the address controls stay unchanged while the enable is high. For that reason the address step and the store step drive identical ALU controls.

Top module: `mcc_control`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows the fetch step's outputs, whatever step was active before.
- R2: The fetch step drives `pc_load`=1, `instr_load`=1, `alu_b_sel`=00 (constant four) and `alu_func`=00. The ALU function codes are add 00, sub 01, or 10 and function-field 11. The B-select codes are 00 constant four, 01 register B, 10 shifted immediate and 11 extended immediate.
- R3: The step after fetch is always decode. Decode drives `target_load`=1, `imm_signed`=1, `alu_a_reg`=0, `alu_b_sel`=10 and `alu_func`=00.
- R4: Opcode 000100 (branch-if-equal) runs fetch, decode, then one compare step with `pc_load_if_zero`=1, `pc_from_target`=1, `alu_a_reg`=1, `alu_b_sel`=01 and `alu_func`=01, and then returns to fetch.
- R5: Opcode 000000 (R-type) runs an execute step with `dest_sel_rd`=1, `alu_a_reg`=1, `alu_b_sel`=01 and `alu_func`=11, then a finish step with the same values plus `rf_write`=1, and then returns to fetch.
- R6: Opcode 001101 (or-immediate) runs an execute step with `alu_a_reg`=1, `alu_b_sel`=11, `alu_func`=10, `imm_signed`=0 and `dest_sel_rd`=0, then a finish step with the same values plus `rf_write`=1, and then returns to fetch.
- R7: Opcode 100011 (load) runs an address step with `imm_signed`=1, `alu_a_reg`=1, `alu_b_sel`=11 and `alu_func`=00. It is followed by a read step that adds `mem_addr_sel`=1, then a write-back step that adds `rf_write`=1 and `wb_from_mem`=1, and then fetch. Five cycles in all.
- R8: Opcode 101011 (store) runs the same address step, then a store step that adds `mem_write`=1, and then returns to fetch.
- R9: Any other opcode seen in decode returns the machine to fetch on the next clock.
- R10: Every output not named for a step is 0 in that step.
- R11: A change of `opcode` outside the decode step has no effect on the sequence or on the outputs.
- R12: `mem_write` is high only in a cycle whose previous cycle drove identical address controls (`alu_a_reg`=1, `alu_b_sel`=11, `alu_func`=00, `imm_signed`=1). No two of `pc_load`, `target_load`, `mem_write` and `rf_write` are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to fetch |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_zero | output | 1 | Program counter write when the ALU zero flag is set |
| pc_from_target | output | 1 | Program counter source: 1 = target register |
| target_load | output | 1 | Branch target register write |
| mem_addr_sel | output | 1 | Memory read address: 1 = ALU result, 0 = program counter |
| mem_write | output | 1 | Data memory write enable |
| instr_load | output | 1 | Instruction register write |
| dest_sel_rd | output | 1 | Register write address: 1 = rd field, 0 = rt field |
| rf_write | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Register write data: 1 = memory, 0 = ALU |
| imm_signed | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_a_reg | output | 1 | ALU A operand: 1 = register A, 0 = program counter |
| alu_b_sel | output | 2 | ALU B operand select |
| alu_func | output | 2 | Coarse ALU function |

## Verification
On every cycle, the assertions check four things. Reset leads to the fetch controls. Fetch is always followed by decode. Every completion step hands back to fetch. No two write enables are ever high together. The store-after-address rule and the load's read-before-write-back ordering are also checked on every cycle. The full per-step output words, the cycle count of each class, the handling of unknown opcodes, the disregard of opcode changes outside decode and a reset that lands mid-load are shown only by the bench's scenarios.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_BR_DONE = 4'd2,
        ST_R_EXEC  = 4'd3,
        ST_R_DONE  = 4'd4,
        ST_I_EXEC  = 4'd5,
        ST_I_DONE  = 4'd6,
        ST_ADDR    = 4'd7,
        ST_ST_MEM  = 4'd8,
        ST_LD_MEM  = 4'd9,
        ST_LD_WB   = 4'd10
    } step_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_OR  = 2'b10,
        FN_FLD = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        BSEL_FOUR  = 2'b00,
        BSEL_REGB  = 2'b01,
        BSEL_SHIMM = 2'b10,
        BSEL_EXIMM = 2'b11
    } bsel_e;

    typedef struct packed {
        logic    pc_load;
        logic    pc_load_if_zero;
        logic    pc_from_target;
        logic    target_load;
        logic    mem_addr_sel;
        logic    mem_write;
        logic    instr_load;
        logic    dest_sel_rd;
        logic    rf_write;
        logic    wb_from_mem;
        logic    imm_signed;
        logic    alu_a_reg;
        bsel_e   alu_b_sel;
        alu_fn_e alu_func;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        c.alu_b_sel = BSEL_FOUR;
        c.alu_func  = FN_ADD;
        return c;
    endfunction

    // Shared operand setup of the address, store and load steps.
    function automatic ctrl_t ctrl_addr_base();
        ctrl_t c;
        c = ctrl_idle();
        c.imm_signed = 1'b1;
        c.alu_a_reg  = 1'b1;
        c.alu_b_sel  = BSEL_EXIMM;
        c.alu_func   = FN_ADD;
        return c;
    endfunction

endpackage

// File: rtl/mcc_next_step.sv
module mcc_next_step
    import mcc_pkg::*;
(
    input  step_e            cur,
    input  logic [OPC_W-1:0] opcode,
    output step_e            nxt
);
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OPC_BEQ:   nxt = ST_BR_DONE;
                    OPC_RTYPE: nxt = ST_R_EXEC;
                    OPC_ORI:   nxt = ST_I_EXEC;
                    OPC_LOAD,
                    OPC_STORE: nxt = ST_ADDR;
                    default:   nxt = ST_FETCH;
                endcase
            end
            ST_R_EXEC: nxt = ST_R_DONE;
            ST_I_EXEC: nxt = ST_I_DONE;
            ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_ST_MEM : ST_LD_MEM;
            ST_LD_MEM: nxt = ST_LD_WB;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_step_reg.sv
module mcc_step_reg
    import mcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e nxt,
    input  logic  [OPC_W-1:0] opcode,
    output step_e cur,
    output logic  [OPC_W-1:0] opc_latched
);
    // The opcode is captured in decode so later steps ignore the input.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= ST_FETCH;
            opc_latched <= '0;
        end else begin
            cur <= nxt;
            if (cur == ST_DECODE)
                opc_latched <= opcode;
        end
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  step_e cur,
    output ctrl_t ctl
);
    always_comb begin
        ctl = ctrl_idle();
        unique case (cur)
            ST_FETCH: begin
                ctl.pc_load    = 1'b1;
                ctl.instr_load = 1'b1;
            end
            ST_DECODE: begin
                ctl.target_load = 1'b1;
                ctl.imm_signed  = 1'b1;
                ctl.alu_b_sel   = BSEL_SHIMM;
            end
            ST_BR_DONE: begin
                ctl.pc_load_if_zero = 1'b1;
                ctl.pc_from_target  = 1'b1;
                ctl.alu_a_reg       = 1'b1;
                ctl.alu_b_sel       = BSEL_REGB;
                ctl.alu_func        = FN_SUB;
            end
            ST_R_EXEC, ST_R_DONE: begin
                ctl.dest_sel_rd = 1'b1;
                ctl.alu_a_reg   = 1'b1;
                ctl.alu_b_sel   = BSEL_REGB;
                ctl.alu_func    = FN_FLD;
                ctl.rf_write    = (cur == ST_R_DONE);
            end
            ST_I_EXEC, ST_I_DONE: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSEL_EXIMM;
                ctl.alu_func  = FN_OR;
                ctl.rf_write  = (cur == ST_I_DONE);
            end
            ST_ADDR: ctl = ctrl_addr_base();
            ST_ST_MEM: begin
                ctl = ctrl_addr_base();
                ctl.mem_write = 1'b1;
            end
            ST_LD_MEM: begin
                ctl = ctrl_addr_base();
                ctl.mem_addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctl = ctrl_addr_base();
                ctl.rf_write    = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            default: ctl = ctrl_idle();
        endcase
    end
endmodule

// File: rtl/mcc_control.sv
module mcc_control
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_load,
    output logic             pc_load_if_zero,
    output logic             pc_from_target,
    output logic             target_load,
    output logic             mem_addr_sel,
    output logic             mem_write,
    output logic             instr_load,
    output logic             dest_sel_rd,
    output logic             rf_write,
    output logic             wb_from_mem,
    output logic             imm_signed,
    output logic             alu_a_reg,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_func
);
    step_e            cur_step;
    step_e            nxt_step;
    logic [OPC_W-1:0] opc_held;
    logic [OPC_W-1:0] opc_route;
    ctrl_t            ctl;

    // In decode the live opcode steers; afterwards the captured copy does.
    assign opc_route = (cur_step == ST_DECODE) ? opcode : opc_held;

    mcc_next_step u_next (
        .cur    (cur_step),
        .opcode (opc_route),
        .nxt    (nxt_step)
    );

    mcc_step_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .nxt         (nxt_step),
        .opcode      (opcode),
        .cur         (cur_step),
        .opc_latched (opc_held)
    );

    mcc_ctrl_decode u_dec (
        .cur (cur_step),
        .ctl (ctl)
    );

    assign pc_load         = ctl.pc_load;
    assign pc_load_if_zero = ctl.pc_load_if_zero;
    assign pc_from_target  = ctl.pc_from_target;
    assign target_load     = ctl.target_load;
    assign mem_addr_sel    = ctl.mem_addr_sel;
    assign mem_write       = ctl.mem_write;
    assign instr_load      = ctl.instr_load;
    assign dest_sel_rd     = ctl.dest_sel_rd;
    assign rf_write        = ctl.rf_write;
    assign wb_from_mem     = ctl.wb_from_mem;
    assign imm_signed      = ctl.imm_signed;
    assign alu_a_reg       = ctl.alu_a_reg;
    assign alu_b_sel       = ctl.alu_b_sel;
    assign alu_func        = ctl.alu_func;
endmodule

// File: rtl/mcc_control_chk.sv
module mcc_control_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_load,
    input logic       pc_load_if_zero,
    input logic       target_load,
    input logic       mem_addr_sel,
    input logic       mem_write,
    input logic       instr_load,
    input logic       rf_write,
    input logic       wb_from_mem,
    input logic       imm_signed,
    input logic       alu_a_reg,
    input logic [1:0] alu_b_sel,
    input logic [1:0] alu_func
);
    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (pc_load && instr_load && !rf_write && !mem_write));

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (target_load && !pc_load));

    // R12
    store_addr_settled_chk: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> $past(alu_a_reg && alu_b_sel == 2'b11 &&
                            alu_func == 2'b00 && imm_signed && !mem_write));

    // R12
    single_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_load, target_load, mem_write, rf_write}));

    // R7
    load_read_first_chk: assert property (@(posedge clk) disable iff (rst)
        wb_from_mem |-> $past(mem_addr_sel));

    // R4
    completion_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_write || mem_write || pc_load_if_zero) |=> (pc_load && instr_load));
endmodule

bind mcc_control mcc_control_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .pc_load         (pc_load),
    .pc_load_if_zero (pc_load_if_zero),
    .target_load     (target_load),
    .mem_addr_sel    (mem_addr_sel),
    .mem_write       (mem_write),
    .instr_load      (instr_load),
    .rf_write        (rf_write),
    .wb_from_mem     (wb_from_mem),
    .imm_signed      (imm_signed),
    .alu_a_reg       (alu_a_reg),
    .alu_b_sel       (alu_b_sel),
    .alu_func        (alu_func)
);

// File: tb/tb_mcc_control.sv
module tb_mcc_control;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic pc_load, pc_load_if_zero, pc_from_target, target_load, mem_addr_sel;
    logic mem_write, instr_load, dest_sel_rd, rf_write, wb_from_mem;
    logic imm_signed, alu_a_reg;
    logic [1:0] alu_b_sel, alu_func;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    mcc_control dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .pc_from_target(pc_from_target), .target_load(target_load),
        .mem_addr_sel(mem_addr_sel), .mem_write(mem_write),
        .instr_load(instr_load), .dest_sel_rd(dest_sel_rd),
        .rf_write(rf_write), .wb_from_mem(wb_from_mem),
        .imm_signed(imm_signed), .alu_a_reg(alu_a_reg),
        .alu_b_sel(alu_b_sel), .alu_func(alu_func)
    );

    // Word order: pcld, pcz, pctgt, tgt, maddr, mwr, irld, rd, rfw, wbm, sext, areg, bsel[2], fn[2]
    function automatic logic [15:0] pack_word(
        bit pcld, bit pcz, bit pctgt, bit tgt, bit maddr, bit mwr, bit irld,
        bit rd, bit rfw, bit wbm, bit sext, bit areg, bit [1:0] b, bit [1:0] fn);
        return {pcld, pcz, pctgt, tgt, maddr, mwr, irld, rd, rfw, wbm, sext, areg, b, fn};
    endfunction

    function automatic logic [15:0] w_fetch();  return pack_word(1,0,0,0,0,0,1,0,0,0,0,0,2'b00,2'b00); endfunction
    function automatic logic [15:0] w_decode(); return pack_word(0,0,0,1,0,0,0,0,0,0,1,0,2'b10,2'b00); endfunction
    function automatic logic [15:0] w_branch(); return pack_word(0,1,1,0,0,0,0,0,0,0,0,1,2'b01,2'b01); endfunction
    function automatic logic [15:0] w_rexec(bit fin); return pack_word(0,0,0,0,0,0,0,1,fin,0,0,1,2'b01,2'b11); endfunction
    function automatic logic [15:0] w_iexec(bit fin); return pack_word(0,0,0,0,0,0,0,0,fin,0,0,1,2'b11,2'b10); endfunction
    function automatic logic [15:0] w_mem(bit maddr, bit mwr, bit rfw, bit wbm);
        return pack_word(0,0,0,0,maddr,mwr,0,0,rfw,wbm,1,1,2'b11,2'b00);
    endfunction

    function automatic logic [15:0] outs();
        return {pc_load, pc_load_if_zero, pc_from_target, target_load, mem_addr_sel,
                mem_write, instr_load, dest_sel_rd, rf_write, wb_from_mem,
                imm_signed, alu_a_reg, alu_b_sel, alu_func};
    endfunction

    task automatic push(input logic [15:0] w, input string r);
        exp_q.push_back(w);
        req_q.push_back(r);
    endtask

    task automatic direct_check(input logic [15:0] e, input string r);
        checks++;
        if (outs() !== e) begin
            errors++;
            $display("FAIL %s: outputs %h expected %h", r, outs(), e);
        end
    endtask

    // Monitor: compares one expected word per cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [15:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            direct_check(e, r);
        end
    end

    // Driver: called 1 ns after the edge that entered fetch.
    task automatic run_instr(input logic [5:0] opc, input bit glitch, input logic [5:0] alt);
        opcode = opc;
        push(w_fetch(), "R2 fetch");
        push(w_decode(), "R3 decode");
        case (opc)
            6'b000100: push(w_branch(), "R4 branch compare");
            6'b000000: begin
                push(w_rexec(0), glitch ? "R11 rtype exec" : "R5 rtype exec");
                push(w_rexec(1), glitch ? "R11 rtype finish" : "R5 rtype finish");
            end
            6'b001101: begin
                push(w_iexec(0), "R6 ori exec");
                push(w_iexec(1), "R6 ori finish");
            end
            6'b100011: begin
                push(w_mem(0,0,0,0), glitch ? "R11 load addr" : "R7 load addr");
                push(w_mem(1,0,0,0), glitch ? "R11 load read" : "R7 load read");
                push(w_mem(0,0,1,1), glitch ? "R11 load writeback" : "R7 load writeback");
            end
            6'b101011: begin
                push(w_mem(0,0,0,0), "R8 store addr");
                push(w_mem(0,1,0,0), "R8 store write R12");
            end
            default: ;
        endcase
        if (glitch) begin
            repeat (2) @(posedge clk);
            #1 opcode = alt;
        end
        while (exp_q.size() != 0) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        opcode = 6'b111111;
        repeat (3) @(posedge clk);
        #1 direct_check(w_fetch(), "R1 reset state R10");
        rst = 1'b0;
        run_instr(6'b000100, 0, 0);
        run_instr(6'b000000, 0, 0);
        run_instr(6'b001101, 0, 0);
        run_instr(6'b100011, 0, 0);
        run_instr(6'b101011, 0, 0);
        run_instr(6'b111111, 0, 0);            // R9 unknown
        run_instr(6'b000010, 0, 0);            // R9 unknown
        run_instr(6'b000000, 1, 6'b000100);    // R11 opcode change mid R-type
        run_instr(6'b100011, 1, 6'b101011);    // R11 load not turned into store
        run_instr(6'b101011, 0, 0);
        // R1 reset lands during the load read step
        opcode = 6'b100011;
        push(w_fetch(), "R2 fetch");
        push(w_decode(), "R3 decode");
        push(w_mem(0,0,0,0), "R7 load addr");
        while (exp_q.size() != 0) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 direct_check(w_fetch(), "R1 reset mid load");
        rst = 1'b0;
        run_instr(6'b001101, 0, 0);
        run_instr(6'b000100, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule